// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the byte-wide host-facing control register file of an audio codec. The host sees four direct byte ports. The first is an index pointer and the second is a data window onto a bank of indirect registers. The third is an interrupt status port and the fourth is a programmed-I/O data port, which ignores writes. The data window reaches 16 indirect registers in the legacy mode and 32 in the extended mode. A mode bit held in the bank itself selects between the two.

Some locations carry side effects. A mode-change-enable bit in the index pointer gates changes to the playback format register. A playback-done event from neighbouring logic raises an interrupt level and a playback-interrupt flag. The host clears both through the status port or the feature status register. After mode-change-enable is raised, a short calibration-in-progress indication is shown on reads of the error/initialisation register. Accepted writes to the format and configuration registers emit a one-cycle strobe carrying the stored value. The audio data path, DMA and clocking lie outside this block.

Top module: `codec_regfile`

## Requirements
- R1: Port encoding is addr_i 0 = index, 1 = data window, 2 = status, 3 = PIO data. The index port resets to 0x40 and stores bits 6:0 of a write. Bit 7 always reads 0. Bit 6 is the mode-change-enable (MCE) flag.
- R2: The data window selects indirect register index[3:0] when bit 6 of register 12 is 0, and index[4:0] when that bit is 1.
- R3: Reset values are 0x88 at 2..5, 18 and 19, 0x80 at 6 and 7, 0x08 at 9, 0x8A at 12, 0xA0 at 25 and 26, and 0x00 everywhere else.
- R4: A write to register 12 changes only its bit 6.
- R5: Writes to registers 11, 22, 27 and 29 and to the PIO port leave all state unchanged.
- R6: A write to register 9 stores the value with bit 5 cleared. cfg_o mirrors register 9.
- R7: A write to register 8 stores the whole byte when MCE is 1. When MCE is 0 and register 24 bit 4 is 1, it replaces only bits 7:4. Otherwise it is dropped. fmt_o mirrors register 8.
- R8: An accepted write to register 8 or register 9 drives fmt_stb_o or cfg_stb_o high for exactly the next cycle, with stb_data_o equal to the value stored.
- R9: A play_done_i pulse sets the interrupt flag and register 24 bit 4 at the next edge. irq_o equals the interrupt flag. A set wins over a clear in the same cycle.
- R10: Any write to the status port clears the interrupt flag and bits 6:4 of register 24.
- R11: A write to register 24 that takes bit 4 from 1 to 0 clears the interrupt flag. A write that keeps bit 4 at 1 does not.
- R12: An index write that raises MCE from 0 to 1 while register 9 bits 4:3 are nonzero loads a counter with CAL_PRESET. Each data-window read of register 11 while the counter is nonzero returns bit 5 set and decrements the counter.
- R13: The status port reads the interrupt flag in bit 0 with bits 7:1 zero. The PIO port reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Direct port select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current access (combinational) |
| play_done_i | input | 1 | Playback block-complete event |
| irq_o | output | 1 | Interrupt level |
| fmt_stb_o | output | 1 | Format register accepted write |
| cfg_stb_o | output | 1 | Configuration register write |
| stb_data_o | output | 8 | Value stored by the strobed write |
| fmt_o | output | 8 | Current format register |
| cfg_o | output | 8 | Current configuration register |

## Verification
The bench targets the aliasing of indices 16 and up onto 0..15 in legacy mode. If the mode bit is ignored, reading index 0x17 returns the legacy register 7 value 0x80 instead of 0x00. It drives the three-way format gate: a design that ignores register 24 bit 4 drops the partial update or writes the low nibble. It also probes the calibration counter. A level-sensitive load instead of an edge-sensitive one keeps bit 5 set on repeated reads, and a missing register-9 qualifier shows the flag when bits 4:3 are zero. Clearing of the interrupt is checked from both paths, including a feature-status write that keeps bit 4 high and must not clear it.

// File: rtl/codec_regfile_pkg.sv
package codec_regfile_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    PORT_INDEX  = 2'd0,
    PORT_DATA   = 2'd1,
    PORT_STATUS = 2'd2,
    PORT_PIO    = 2'd3
  } port_e;

  localparam int R_FMT   = 8;
  localparam int R_CFG   = 9;
  localparam int R_ERR   = 11;
  localparam int R_MODE  = 12;
  localparam int R_RSV_A = 22;
  localparam int R_AFS   = 24;
  localparam int R_RSV_B = 27;
  localparam int R_RSV_C = 29;

  localparam int MODE_BIT = 6;
  localparam int MCE_BIT  = 6;
  localparam int PI_BIT   = 4;
  localparam int CAL_BIT  = 5;
  localparam int CFG_RSV  = 5;

  function automatic logic [DW-1:0] reg_reset(int unsigned i);
    case (i)
      2, 3, 4, 5, 18, 19: return 8'h88;
      6, 7:               return 8'h80;
      9:                  return 8'h08;
      12:                 return 8'h8A;
      25, 26:             return 8'hA0;
      default:            return 8'h00;
    endcase
  endfunction

  function automatic bit reg_locked(int unsigned i);
    return (i == R_ERR) || (i == R_RSV_A) || (i == R_RSV_B) || (i == R_RSV_C);
  endfunction
endpackage

// File: rtl/cr_index_ctl.sv
module cr_index_ctl #(
  parameter int AW         = 5,
  parameter int LAW        = 4,
  parameter int CAL_PRESET = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [6:0]    wdata_i,
  input  logic          ext_mode_i,
  input  logic          cal_arm_i,
  input  logic          cal_rd_i,
  output logic [6:0]    idx_o,
  output logic [AW-1:0] eff_o,
  output logic          mce_o,
  output logic          cal_busy_o
);
  import codec_regfile_pkg::*;

  localparam int CW = (CAL_PRESET < 1) ? 1 : $clog2(CAL_PRESET + 1);

  logic [6:0]    idx_q;
  logic [CW-1:0] cal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= 7'h40;
    else if (wr_i) idx_q <= wdata_i;
  end

  // load only on a 0->1 edge of MCE
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cal_q <= '0;
    else if (wr_i && !idx_q[MCE_BIT] && wdata_i[MCE_BIT] && cal_arm_i) cal_q <= CW'(CAL_PRESET);
    else if (cal_rd_i && (cal_q != '0)) cal_q <= cal_q - 1'b1;
  end

  assign idx_o      = idx_q;
  assign mce_o      = idx_q[MCE_BIT];
  assign cal_busy_o = (cal_q != '0);
  assign eff_o      = ext_mode_i ? idx_q[AW-1:0] : {{(AW-LAW){1'b0}}, idx_q[LAW-1:0]};
endmodule

// File: rtl/cr_bank.sv
module cr_bank #(
  parameter int NUM_REGS = 32,
  parameter int AW       = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [AW-1:0]            sel_i,
  input  logic [7:0]               wdata_i,
  input  logic                     mce_i,
  input  logic                     flag_clr_i,
  input  logic                     pi_set_i,
  output logic [NUM_REGS-1:0][7:0] regs_o,
  output logic                     fmt_stb_o,
  output logic                     cfg_stb_o,
  output logic [7:0]               stb_data_o,
  output logic                     pi_fall_o
);
  import codec_regfile_pkg::*;

  logic       pmce;
  logic       fmt_ok, cfg_hit;
  logic [7:0] fmt_val, cfg_val;

  assign pmce    = regs_o[R_AFS][PI_BIT];
  assign fmt_ok  = wr_i && (sel_i == AW'(R_FMT)) && (mce_i || pmce);
  assign fmt_val = mce_i ? wdata_i : {wdata_i[7:4], regs_o[R_FMT][3:0]};
  assign cfg_hit = wr_i && (sel_i == AW'(R_CFG));
  assign cfg_val = wdata_i & ~(8'h1 << CFG_RSV);
  assign pi_fall_o = wr_i && (sel_i == AW'(R_AFS)) && pmce && !wdata_i[PI_BIT];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] RV = reg_reset(i);
    if (reg_locked(i)) begin : g_const
      assign regs_o[i] = RV;
    end else if (i == R_FMT) begin : g_fmt
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_o[i] <= RV;
        else if (fmt_ok) regs_o[i] <= fmt_val;
      end
    end else if (i == R_CFG) begin : g_cfg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_o[i] <= RV;
        else if (cfg_hit) regs_o[i] <= cfg_val;
      end
    end else if (i == R_MODE) begin : g_mode
      logic hit;
      assign hit = wr_i && (sel_i == AW'(i));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_o[i] <= RV;
        else if (hit) regs_o[i][MODE_BIT] <= wdata_i[MODE_BIT];
      end
    end else if (i == R_AFS) begin : g_afs
      logic       hit;
      logic [7:0] nxt;
      assign hit = wr_i && (sel_i == AW'(i));
      always_comb begin
        nxt = hit ? wdata_i : regs_o[i];
        if (flag_clr_i) nxt[6:4] = 3'b000;
        if (pi_set_i)   nxt[PI_BIT] = 1'b1;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_o[i] <= RV;
        else regs_o[i] <= nxt;
      end
    end else begin : g_plain
      logic hit;
      assign hit = wr_i && (sel_i == AW'(i));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_o[i] <= RV;
        else if (hit) regs_o[i] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_stb_o  <= 1'b0;
      cfg_stb_o  <= 1'b0;
      stb_data_o <= '0;
    end else begin
      fmt_stb_o <= fmt_ok;
      cfg_stb_o <= cfg_hit;
      if (fmt_ok)       stb_data_o <= fmt_val;
      else if (cfg_hit) stb_data_o <= cfg_val;
    end
  end
endmodule

// File: rtl/cr_irq.sv
module cr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins so a completion event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile #(
  parameter int NUM_REGS    = 32,
  parameter int LEGACY_REGS = 16,
  parameter int CAL_PRESET  = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       play_done_i,
  output logic       irq_o,
  output logic       fmt_stb_o,
  output logic       cfg_stb_o,
  output logic [7:0] stb_data_o,
  output logic [7:0] fmt_o,
  output logic [7:0] cfg_o
);
  import codec_regfile_pkg::*;

  localparam int AW  = $clog2(NUM_REGS);
  localparam int LAW = $clog2(LEGACY_REGS);

  port_e                    port;
  logic                     idx_wr, data_wr, stat_wr, data_rd;
  logic [6:0]               idx;
  logic [AW-1:0]            eff;
  logic                     mce, cal_busy, cal_rd, pi_fall, int_flag;
  logic [NUM_REGS-1:0][7:0] regs;
  logic [7:0]               win_rd;

  assign port    = port_e'(addr_i);
  assign idx_wr  = req_i && we_i && (port == PORT_INDEX);
  assign data_wr = req_i && we_i && (port == PORT_DATA);
  assign stat_wr = req_i && we_i && (port == PORT_STATUS);
  assign data_rd = req_i && !we_i && (port == PORT_DATA);
  assign cal_rd  = data_rd && (eff == AW'(R_ERR));

  cr_index_ctl #(.AW(AW), .LAW(LAW), .CAL_PRESET(CAL_PRESET)) u_index (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (idx_wr),
    .wdata_i    (wdata_i[6:0]),
    .ext_mode_i (regs[R_MODE][MODE_BIT]),
    .cal_arm_i  (|regs[R_CFG][4:3]),
    .cal_rd_i   (cal_rd),
    .idx_o      (idx),
    .eff_o      (eff),
    .mce_o      (mce),
    .cal_busy_o (cal_busy)
  );

  cr_bank #(.NUM_REGS(NUM_REGS), .AW(AW)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (data_wr),
    .sel_i      (eff),
    .wdata_i    (wdata_i),
    .mce_i      (mce),
    .flag_clr_i (stat_wr),
    .pi_set_i   (play_done_i),
    .regs_o     (regs),
    .fmt_stb_o  (fmt_stb_o),
    .cfg_stb_o  (cfg_stb_o),
    .stb_data_o (stb_data_o),
    .pi_fall_o  (pi_fall)
  );

  cr_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (play_done_i),
    .clr_i  (stat_wr || pi_fall),
    .flag_o (int_flag)
  );

  always_comb begin
    win_rd = regs[eff];
    if ((eff == AW'(R_ERR)) && cal_busy) win_rd[CAL_BIT] = 1'b1;
  end

  always_comb begin
    unique case (port)
      PORT_INDEX:  rdata_o = {1'b0, idx};
      PORT_DATA:   rdata_o = win_rd;
      PORT_STATUS: rdata_o = {7'b0, int_flag};
      default:     rdata_o = 8'h00;
    endcase
  end

  assign irq_o = int_flag;
  assign fmt_o = regs[R_FMT];
  assign cfg_o = regs[R_CFG];
endmodule

// File: rtl/codec_regfile_chk.sv
module codec_regfile_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic [1:0] addr_i,
  input logic [7:0] rdata_o,
  input logic       play_done_i,
  input logic       irq_o,
  input logic       fmt_stb_o,
  input logic       cfg_stb_o,
  input logic [7:0] stb_data_o
);
  assert_idx_msb_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 2'd0) |-> !rdata_o[7]);

  assert_cfg_bit5_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_stb_o |-> !stb_data_o[5]);

  assert_fmt_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_stb_o |-> $past(req_i && we_i && addr_i == 2'd1));

  assert_stb_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fmt_stb_o, cfg_stb_o}));

  assert_irq_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    play_done_i |=> irq_o);

  assert_irq_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 2'd2 && !play_done_i) |=> !irq_o);

  assert_stat_read_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 2'd2) |-> (rdata_o[7:1] == 7'd0 && rdata_o[0] == irq_o));

  assert_pio_read_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 2'd3) |-> (rdata_o == 8'h00));
endmodule

bind codec_regfile codec_regfile_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .rdata_o     (rdata_o),
  .play_done_i (play_done_i),
  .irq_o       (irq_o),
  .fmt_stb_o   (fmt_stb_o),
  .cfg_stb_o   (cfg_stb_o),
  .stb_data_o  (stb_data_o)
);

// File: tb/sim_codec_regfile.sv
`timescale 1ns/1ps
module sim_codec_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0, done = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, stb_data, fmt, cfg;
  logic       irq, fstb, cstb;

  int n_chk = 0, n_fail = 0;

  // reference model state
  int m_r[32];
  int m_idx, m_int, m_cal, m_fstb, m_cstb, m_sdat;

  always #10 clk = ~clk;

  codec_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .play_done_i(done), .irq_o(irq),
    .fmt_stb_o(fstb), .cfg_stb_o(cstb), .stb_data_o(stb_data),
    .fmt_o(fmt), .cfg_o(cfg)
  );

  function automatic int rv(int i);
    if (i >= 2 && i <= 5) return 'h88;
    if (i == 18 || i == 19) return 'h88;
    if (i == 6 || i == 7) return 'h80;
    if (i == 9) return 'h08;
    if (i == 12) return 'h8A;
    if (i == 25 || i == 26) return 'hA0;
    return 0;
  endfunction

  function automatic int m_eff();
    return (m_r[12] & 'h40) ? (m_idx & 31) : (m_idx & 15);
  endfunction

  function automatic int m_read(int a);
    int e;
    case (a)
      0: return m_idx;
      1: begin
        e = m_eff();
        return m_r[e] | ((e == 11 && m_cal > 0) ? 'h20 : 0);
      end
      2: return m_int;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_r[i] = rv(i);
      m_idx = 'h40; m_int = 0; m_cal = 0; m_fstb = 0; m_cstb = 0; m_sdat = 0;
    end else begin
      int e, d;
      m_fstb = 0; m_cstb = 0;
      d = int'(wdata);
      e = m_eff();
      if (req && we) begin
        case (addr)
          2'd0: begin
            if (!(m_idx & 'h40) && (d & 'h40) && (((m_r[9] >> 3) & 3) != 0)) m_cal = 1;
            m_idx = d & 'h7F;
          end
          2'd1: begin
            case (e)
              11, 22, 27, 29: ;
              8: begin
                if (m_idx & 'h40) begin m_r[8] = d; m_fstb = 1; m_sdat = d; end
                else if (m_r[24] & 'h10) begin
                  m_r[8] = (d & 'hF0) | (m_r[8] & 'h0F); m_fstb = 1; m_sdat = m_r[8];
                end
              end
              9: begin m_r[9] = d & 'hDF; m_cstb = 1; m_sdat = m_r[9]; end
              12: m_r[12] = (m_r[12] & 'hBF) | (d & 'h40);
              24: begin
                if ((m_r[24] & 'h10) && !(d & 'h10)) m_int = 0;
                m_r[24] = d;
              end
              default: m_r[e] = d;
            endcase
          end
          2'd2: begin m_int = 0; m_r[24] = m_r[24] & 'h8F; end
          default: ;
        endcase
      end
      if (req && !we && addr == 2'd1 && e == 11 && m_cal > 0) m_cal--;
      if (done) begin m_int = 1; m_r[24] = m_r[24] | 'h10; end
    end
  end

  // cycle-by-cycle comparison of registered outputs
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 irq", int'(irq), m_int);
      chk("R8 fmt strobe", int'(fstb), m_fstb);
      chk("R8 cfg strobe", int'(cstb), m_cstb);
      if (fstb || cstb) chk("R8 strobe data", int'(stb_data), m_sdat);
      chk("R7 fmt mirror", int'(fmt), m_r[8]);
      chk("R6 cfg mirror", int'(cfg), m_r[9]);
    end
  end

  task automatic acc(bit w, bit [1:0] a, bit [7:0] d, bit dn);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; done = dn;
    if (!w) begin
      #2;
      chk("R1 R2 R13 model read", int'(rdata), m_read(int'(a)));
    end
    @(posedge clk);
    #1;
    req = 1'b0; done = 1'b0;
  endtask

  task automatic wr(bit [1:0] a, bit [7:0] d);
    acc(1'b1, a, d, 1'b0);
  endtask

  task automatic rd_exp(bit [1:0] a, int exp, string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #2;
    chk(tag, int'(rdata), exp);
    @(posedge clk);
    #1;
    req = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    done = 1'b1;
    @(posedge clk);
    #1;
    done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd_exp(2'd0, 'h40, "R1 index reset");
    rd_exp(2'd2, 'h00, "R13 status reset");
    for (int i = 0; i < 16; i++) begin
      wr(2'd0, 8'(8'h40 | i));
      rd_exp(2'd1, rv(i), "R3 legacy reset value");
    end
    wr(2'd0, 8'h52);
    rd_exp(2'd0, 'h52, "R1 index store");
    rd_exp(2'd1, 'h88, "R2 legacy alias of 18 onto 2");
    wr(2'd0, 8'hC4);
    rd_exp(2'd0, 'h44, "R1 bit7 reads zero");

    wr(2'd0, 8'h4C);
    wr(2'd1, 8'hFF);
    rd_exp(2'd1, 'hCA, "R4 mode only bit6");
    wr(2'd1, 8'h00);
    rd_exp(2'd1, 'h8A, "R4 mode bit6 clear");
    wr(2'd1, 8'h40);
    for (int i = 16; i < 32; i++) begin
      wr(2'd0, 8'(8'h40 | i));
      rd_exp(2'd1, rv(i), "R3 extended reset value");
    end
    wr(2'd0, 8'h57);
    rd_exp(2'd1, 'h00, "R2 extended index 23");

    foreach (m_r[k]) if (k == 11 || k == 22 || k == 27 || k == 29) begin
      wr(2'd0, 8'(8'h40 | k));
      wr(2'd1, 8'h5A);
      rd_exp(2'd1, rv(k), "R5 locked register");
    end
    wr(2'd3, 8'h77);
    rd_exp(2'd3, 'h00, "R13 PIO read zero");
    rd_exp(2'd0, 'h5D, "R5 PIO write no effect");

    wr(2'd0, 8'h49);
    wr(2'd1, 8'hFF);
    chk("R8 cfg strobe", int'(cstb), 1);
    chk("R8 cfg strobe data", int'(stb_data), 'hDF);
    rd_exp(2'd1, 'hDF, "R6 cfg bit5 cleared");

    wr(2'd0, 8'h48);
    wr(2'd1, 8'h5A);
    chk("R8 fmt strobe", int'(fstb), 1);
    chk("R7 fmt full write", int'(fmt), 'h5A);
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h3C);
    chk("R8 dropped fmt no strobe", int'(fstb), 0);
    rd_exp(2'd1, 'h5A, "R7 fmt write dropped");
    wr(2'd0, 8'h18);
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h08);
    wr(2'd1, 8'hC3);
    chk("R8 fmt partial strobe data", int'(stb_data), 'hCA);
    rd_exp(2'd1, 'hCA, "R7 fmt upper nibble only");

    pulse_done();
    @(negedge clk);
    chk("R9 irq raised", int'(irq), 1);
    rd_exp(2'd2, 'h01, "R13 status shows INT");
    wr(2'd0, 8'h18);
    wr(2'd1, 8'h70);
    @(negedge clk);
    chk("R11 bit4 held keeps irq", int'(irq), 1);
    wr(2'd2, 8'h00);
    @(negedge clk);
    chk("R10 status write clears irq", int'(irq), 0);
    rd_exp(2'd1, 'h00, "R10 flags 6:4 cleared");

    pulse_done();
    rd_exp(2'd1, 'h10, "R9 playback flag set");
    wr(2'd1, 8'h00);
    @(negedge clk);
    chk("R11 bit4 fall clears irq", int'(irq), 0);

    wr(2'd0, 8'h4B);
    rd_exp(2'd1, 'h20, "R12 calibration flag");
    rd_exp(2'd1, 'h00, "R12 calibration expired");
    wr(2'd0, 8'h4B);
    rd_exp(2'd1, 'h00, "R12 no reload while MCE held");
    wr(2'd0, 8'h09);
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h0B);
    wr(2'd0, 8'h4B);
    rd_exp(2'd1, 'h00, "R12 not armed when cfg 4:3 zero");

    for (int n = 0; n < 600; n++) begin
      acc(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
          8'($urandom_range(0, 255)), ($urandom_range(0, 7) == 0));
    end

    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule